// File: doc/BRIEF.md
# Interrupt Redirection Register Interface

This block is the bus-facing register front end of an interrupt redirection controller. Software reaches every internal register through two directly addressed 32-bit locations. It writes an 8-bit index into a select register and then reads or writes the register that index names through a data window. Through the window it reaches an identification register, a computed version register, an arbitration register, and the low and high words of one 64-bit redirection entry per interrupt pin.

The block holds the entry table. Inside each low word it keeps the two status bits that the delivery logic owns (bit 12, delivery busy; bit 14, remote request pending) safe from software writes. The delivery logic sets those bits through a separate status port. Every bus write that lands in an entry raises a one-cycle update strobe with the pin number, so that the delivery logic can re-evaluate that pin. Each request gets exactly one response on the next cycle, and any access narrower or wider than 32 bits is refused with an error flag.

Top module: `irq_regif`

## Requirements
- R1: A request with `busSize` other than 4 (bytes) gets a response next cycle with `rspErr`=1 and `rspRdata`=0, and changes no register.
- R2: The select register sits at offset 0x00 and stores only bits 7:0 of written data. A read of offset 0x00 returns the index zero-extended. Reset clears it to 0.
- R3: A 32-bit read of any offset other than 0x00 and 0x10 returns 32'hFFFF_FFFF without error. A write there changes nothing.
- R4: A window write at index 0x00 stores data AND 32'h0F00_0000 as the ID. Index 0x00 (ID) and index 0x02 (arbitration) both read the ID. Reset clears the ID to 0.
- R5: Index 0x01 reads ((PINS-1) << 16) | 32'h11, which is 32'h0017_0011 for 24 pins. Writes to index 0x01 and 0x02 are ignored.
- R6: Pin p's low word is at index 0x10+2p and its high word at 0x11+2p. The high word takes all 32 written bits. Reset sets every low word to 32'h0001_0000 (bit 16, mask) and every high word to 0.
- R7: A window write to a low word keeps bits 12 and 14 at their previous values and takes all other bits from the data. A `stsValid` cycle sets bit 12 of pin `stsPin` to `stsDeliv` and bit 14 to `stsIrr`.
- R8: A window read of an index that is not 0x00–0x02 and not an entry word (0x03–0x0F, or 0x10+2*PINS and above) returns 0.
- R9: Each accepted window write to an entry word raises `updValid` for one cycle with `updPin` set to the pin, in the same cycle as its response. No other access raises it.
- R10: `rspValid` is high exactly in the cycle after each request (`busValid`), and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busSize | input | 3 | Access size in bytes; only 4 is accepted |
| busWdata | input | 32 | Write data |
| rspValid | output | 1 | Response present, one cycle after request |
| rspErr | output | 1 | Request refused for its size |
| rspRdata | output | 32 | Read data, 0 for writes and errors |
| stsValid | input | 1 | Status bit update from delivery logic |
| stsPin | input | PIN_W | Pin whose status bits are updated |
| stsDeliv | input | 1 | New value of low-word bit 12 |
| stsIrr | input | 1 | New value of low-word bit 14 |
| updValid | output | 1 | Entry word was written by the bus |
| updPin | output | PIN_W | Pin whose entry was written |

## Verification
The bench goes after the protected status bits. It sets them through the status port, overwrites the low word with all-zero and all-one patterns, and expects the bits to survive. A design that merged them blindly would either clear them or let software force them. It probes the index boundaries: 0x03–0x0F and the first index past the last pin must read 0, while the last pin's high word must hold data. An off-by-one range decode would alias a phantom pin or lose the last one. It also refuses narrow accesses to the select register and checks that the index is unchanged afterwards, which catches a design that flags the error but still performs the write.

// File: rtl/irq_regif_pkg.sv
package irq_regif_pkg;
  localparam logic [7:0]  IDX_ID    = 8'h00;
  localparam logic [7:0]  IDX_VER   = 8'h01;
  localparam logic [7:0]  IDX_ARB   = 8'h02;
  localparam logic [7:0]  IDX_ENTRY = 8'h10;
  localparam logic [31:0] ID_KEEP   = 32'h0F00_0000;
  localparam logic [31:0] LO_GUARD  = 32'h0000_5000;
  localparam logic [31:0] LO_RESET  = 32'h0001_0000;
  localparam logic [31:0] VER_CODE  = 32'h0000_0011;
  localparam logic [2:0]  FULL_SIZE = 3'd4;

  typedef enum logic [2:0] {
    RD_ZERO, RD_SEL, RD_ID, RD_VER, RD_LO, RD_HI, RD_ONES
  } rd_src_e;

  typedef struct packed {
    logic    respond;
    logic    err;
    logic    selWe;
    logic    idWe;
    logic    loWe;
    logic    hiWe;
    logic [7:0] pin;
    rd_src_e rdSrc;
  } strobe_t;
endpackage

// File: rtl/irq_regif_ctrl.sv
module irq_regif_ctrl
  import irq_regif_pkg::*;
#(
  parameter int unsigned PINS   = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [7:0]        selQ,
  output strobe_t           st
);
  localparam int unsigned ENTRY_END = 16 + 2 * PINS;

  logic sizeOk, hitSel, hitWin, inEntry, oddWord;
  logic [7:0] entryOff;

  assign sizeOk   = busSize == FULL_SIZE;
  assign hitSel   = busAddr == ADDR_W'(0);
  assign hitWin   = busAddr == ADDR_W'(16);
  assign inEntry  = (selQ >= IDX_ENTRY) && ({24'd0, selQ} < 32'(ENTRY_END));
  assign entryOff = selQ - IDX_ENTRY;
  assign oddWord  = entryOff[0];

  always_comb begin
    st = '0;
    st.rdSrc   = RD_ZERO;
    st.respond = busValid;
    st.err     = busValid && !sizeOk;
    st.pin     = {1'b0, entryOff[7:1]};
    if (busValid && sizeOk) begin
      if (busWrite) begin
        if (hitSel) st.selWe = 1'b1;
        else if (hitWin) begin
          if (selQ == IDX_ID) st.idWe = 1'b1;
          else if (inEntry) begin
            st.loWe = !oddWord;
            st.hiWe = oddWord;
          end
        end
      end else begin
        if (hitSel) st.rdSrc = RD_SEL;
        else if (hitWin) begin
          if (selQ == IDX_ID || selQ == IDX_ARB) st.rdSrc = RD_ID;
          else if (selQ == IDX_VER) st.rdSrc = RD_VER;
          else if (inEntry) st.rdSrc = oddWord ? RD_HI : RD_LO;
        end else st.rdSrc = RD_ONES;
      end
    end
  end
endmodule

// File: rtl/irq_regif_data.sv
module irq_regif_data
  import irq_regif_pkg::*;
#(
  parameter int unsigned PINS  = 24,
  parameter int unsigned PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          st,
  input  logic [31:0]      busWdata,
  input  logic             stsValid,
  input  logic [PIN_W-1:0] stsPin,
  input  logic             stsDeliv,
  input  logic             stsIrr,
  output logic [7:0]       selQ,
  output logic             rspValid,
  output logic             rspErr,
  output logic [31:0]      rspRdata,
  output logic             updValid,
  output logic [PIN_W-1:0] updPin
);
  localparam logic [31:0] VER_WORD = (32'(PINS - 1) << 16) | VER_CODE;

  logic [31:0] idQ;
  logic [31:0] loTab [PINS];
  logic [31:0] hiTab [PINS];
  logic [PIN_W-1:0] pinSel;
  logic [31:0] rdMux;

  assign pinSel = st.pin[PIN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selQ <= '0;
      idQ  <= '0;
    end else begin
      if (st.selWe) selQ <= busWdata[7:0];
      if (st.idWe)  idQ  <= busWdata & ID_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PINS; p++) begin
      if (!rst_n) begin
        loTab[p] <= LO_RESET;
        hiTab[p] <= '0;
      end else begin
        if (st.loWe && pinSel == PIN_W'(p))
          loTab[p] <= (loTab[p] & LO_GUARD) | (busWdata & ~LO_GUARD);
        if (stsValid && stsPin == PIN_W'(p)) begin
          loTab[p][12] <= stsDeliv;
          loTab[p][14] <= stsIrr;
        end
        if (st.hiWe && pinSel == PIN_W'(p)) hiTab[p] <= busWdata;
      end
    end
  end

  always_comb begin
    unique case (st.rdSrc)
      RD_SEL:  rdMux = {24'd0, selQ};
      RD_ID:   rdMux = idQ;
      RD_VER:  rdMux = VER_WORD;
      RD_LO:   rdMux = loTab[pinSel];
      RD_HI:   rdMux = hiTab[pinSel];
      RD_ONES: rdMux = '1;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
      updValid <= 1'b0;
      updPin   <= '0;
    end else begin
      rspValid <= st.respond;
      rspErr   <= st.err;
      rspRdata <= st.respond ? rdMux : '0;
      updValid <= st.loWe || st.hiWe;
      updPin   <= pinSel;
    end
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_regif_pkg::*;
#(
  parameter int unsigned PINS   = 24,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned PIN_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRdata,
  input  logic              stsValid,
  input  logic [PIN_W-1:0]  stsPin,
  input  logic              stsDeliv,
  input  logic              stsIrr,
  output logic              updValid,
  output logic [PIN_W-1:0]  updPin
);
  strobe_t    st;
  logic [7:0] selQ;

  irq_regif_ctrl #(.PINS(PINS), .ADDR_W(ADDR_W)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .selQ(selQ), .st(st)
  );

  irq_regif_data #(.PINS(PINS), .PIN_W(PIN_W)) u_data (
    .clk(clk), .rst_n(rst_n), .st(st), .busWdata(busWdata),
    .stsValid(stsValid), .stsPin(stsPin), .stsDeliv(stsDeliv), .stsIrr(stsIrr),
    .selQ(selQ), .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .updValid(updValid), .updPin(updPin)
  );
endmodule

// File: rtl/irq_regif_chk.sv
module irq_regif_chk #(
  parameter int unsigned PINS   = 24,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PIN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [2:0]        busSize,
  input logic              rspValid,
  input logic              rspErr,
  input logic [31:0]       rspRdata,
  input logic              updValid,
  input logic [7:0]        selQ
);
  localparam logic [31:0] VER_EXP = (32'(PINS - 1) << 16) | 32'h11;
  logic rdOk;
  assign rdOk = busValid && !busWrite && busSize == 3'd4;

  // R1
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busValid && busSize != 3'd4 |=> rspValid && rspErr && rspRdata == 32'd0);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busValid |=> rspValid);
  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busValid |=> !rspValid);
  // R2
  sel_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdOk && busAddr == ADDR_W'(0) |=> rspRdata[31:8] == 24'd0);
  // R3
  stray_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdOk && busAddr != ADDR_W'(0) && busAddr != ADDR_W'(16) |=> rspRdata == 32'hFFFF_FFFF && !rspErr);
  // R4
  id_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdOk && busAddr == ADDR_W'(16) && (selQ == 8'h00 || selQ == 8'h02)
    |=> (rspRdata & ~32'h0F00_0000) == 32'd0);
  // R5
  version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdOk && busAddr == ADDR_W'(16) && selQ == 8'h01 |=> rspRdata == VER_EXP);
  // R8
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdOk && busAddr == ADDR_W'(16) && selQ > 8'h02 && selQ < 8'h10 |=> rspRdata == 32'd0);
  // R9
  upd_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updValid |-> rspValid && !rspErr);
  // R9
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updValid |=> !updValid || rspValid);
endmodule

bind irq_regif irq_regif_chk #(.PINS(PINS), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .rspValid(rspValid), .rspErr(rspErr),
  .rspRdata(rspRdata), .updValid(updValid), .selQ(selQ)
);

// File: tb/irq_regif_test.sv
module irq_regif_test;
  localparam int unsigned PINS = 24;
  localparam int unsigned PIN_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busValid = 0, busWrite = 0;
  logic [7:0] busAddr = 0;
  logic [2:0] busSize = 0;
  logic [31:0] busWdata = 0;
  logic rspValid, rspErr, updValid;
  logic [31:0] rspRdata;
  logic stsValid = 0, stsDeliv = 0, stsIrr = 0;
  logic [PIN_W-1:0] stsPin = 0, updPin;
  int checks = 0, fails = 0;
  logic sUpd; logic [PIN_W-1:0] sPin; logic sErr, sRsp; logic [31:0] sData;

  always #4 clk = ~clk;

  irq_regif #(.PINS(PINS), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .stsValid(stsValid), .stsPin(stsPin), .stsDeliv(stsDeliv), .stsIrr(stsIrr),
    .updValid(updValid), .updPin(updPin)
  );

  typedef struct packed {
    logic wr; logic [7:0] addr; logic [2:0] size; logic [31:0] wdata;
    logic expErr; logic [31:0] expData; logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 3'd4, 32'h0, 1'b0, 32'h0, 4'd2},              // R2 reset sel
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0, 4'd4},              // R4 reset ID
    '{1'b1, 8'h00, 3'd4, 32'h1234_5601, 1'b0, 32'h0, 4'd2},      // R2 wide write
    '{1'b0, 8'h00, 3'd4, 32'h0, 1'b0, 32'h01, 4'd2},             // R2 low byte kept
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0017_0011, 4'd5},      // R5 version
    '{1'b1, 8'h10, 3'd4, 32'hDEAD_BEEF, 1'b0, 32'h0, 4'd5},
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0017_0011, 4'd5},      // R5 write ignored
    '{1'b1, 8'h00, 3'd4, 32'h0, 1'b0, 32'h0, 4'd2},
    '{1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd4},
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0F00_0000, 4'd4},      // R4 ID mask
    '{1'b1, 8'h00, 3'd4, 32'h02, 1'b0, 32'h0, 4'd4},
    '{1'b1, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0, 4'd5},              // R5 arb write ignored
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0F00_0000, 4'd4},      // R4 arb reads ID
    '{1'b1, 8'h00, 3'd4, 32'h05, 1'b0, 32'h0, 4'd8},
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0, 4'd8},              // R8 hole
    '{1'b1, 8'h00, 3'd4, 32'h10, 1'b0, 32'h0, 4'd6},
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0001_0000, 4'd6},      // R6 reset low
    '{1'b1, 8'h00, 3'd4, 32'h11, 1'b0, 32'h0, 4'd6},
    '{1'b1, 8'h10, 3'd4, 32'hA500_0000, 1'b0, 32'h0, 4'd6},
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'hA500_0000, 4'd6},      // R6 high word
    '{1'b1, 8'h00, 3'd4, 32'h40, 1'b0, 32'h0, 4'd8},
    '{1'b0, 8'h10, 3'd4, 32'h0, 1'b0, 32'h0, 4'd8},              // R8 past last pin
    '{1'b0, 8'h04, 3'd4, 32'h0, 1'b0, 32'hFFFF_FFFF, 4'd3},      // R3 stray read
    '{1'b1, 8'h04, 3'd4, 32'h0, 1'b0, 32'h0, 4'd3},
    '{1'b0, 8'h00, 3'd2, 32'h0, 1'b1, 32'h0, 4'd1},              // R1 narrow read
    '{1'b1, 8'h00, 3'd1, 32'h0, 1'b1, 32'h0, 4'd1}               // R1 narrow write
  };

  task automatic access(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busValid = 0;
    sRsp = rspValid; sErr = rspErr; sData = rspRdata; sUpd = updValid; sPin = updPin;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setStatus(input logic [PIN_W-1:0] p, input logic dv, input logic ir);
    @(negedge clk);
    stsValid = 1; stsPin = p; stsDeliv = dv; stsIrr = ir;
    @(negedge clk);
    stsValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: no response while idle after reset
    check("R10 idle", {31'd0, rspValid}, 32'd0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
      check($sformatf("R10 vec%0d rsp", i), {31'd0, sRsp}, 32'd1);
      check($sformatf("R%0d vec%0d err", VECS[i].req, i), {31'd0, sErr}, {31'd0, VECS[i].expErr});
      if (!VECS[i].wr || VECS[i].expErr)
        check($sformatf("R%0d vec%0d data", VECS[i].req, i), sData, VECS[i].expData);
    end
    // R1 and R3: select unchanged by refused and stray writes
    access(0, 8'h00, 3'd4, 0);
    check("R1 R3 sel kept", sData, 32'h40);
    // R6: last pin high word holds data
    access(1, 8'h00, 3'd4, 32'h3F);
    access(1, 8'h10, 3'd4, 32'h1234_5678);
    // R9 strobe for pin 23
    check("R9 upd valid", {31'd0, sUpd}, 32'd1);
    check("R9 upd pin", {27'd0, sPin}, 32'd23);
    access(0, 8'h10, 3'd4, 0);
    check("R6 last high", sData, 32'h1234_5678);
    check("R9 no upd on read", {31'd0, sUpd}, 32'd0);
    // R7: status bits survive software writes
    setStatus(5'd3, 1'b1, 1'b1);
    access(1, 8'h00, 3'd4, 32'h16);
    check("R9 no upd on sel write", {31'd0, sUpd}, 32'd0);
    access(1, 8'h10, 3'd4, 32'h0);
    check("R9 upd pin3", {27'd0, sPin}, 32'd3);
    access(0, 8'h10, 3'd4, 0);
    check("R7 zero write keeps", sData, 32'h0000_5000);
    setStatus(5'd3, 1'b0, 1'b0);
    access(1, 8'h10, 3'd4, 32'hFFFF_FFFF);
    access(0, 8'h10, 3'd4, 0);
    check("R7 ones write keeps", sData, 32'hFFFF_AFFF);
    setStatus(5'd3, 1'b0, 1'b1);
    access(0, 8'h10, 3'd4, 0);
    check("R7 irr set", sData, 32'hFFFF_EFFF);
    // R4 reset restores ID and select
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    access(0, 8'h10, 3'd4, 0);
    check("R4 ID after reset", sData, 32'h0);
    access(0, 8'h00, 3'd4, 0);
    check("R2 sel after reset", sData, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule